// File: doc/BRIEF.md
# Edge-to-Level Interrupt Bridge

This block collects a single edge-signalled interrupt request, shared by several legacy peripherals, and turns it into one level-signalled, active-low interrupt line that can be shared on a PCI-style bus. The request input is asynchronous. It is brought into the bus clock domain by a multi-stage synchronizer. Its active edge is then detected and sets a sticky latch. The latch never follows the input directly. Once set, it stays set until software acknowledges it.

Software reaches the block through a small word-addressed register port. It can read whether the latch is set, whatever the mask setting. It can open or close an enable that gates the interrupt line. It can clear the latch by writing a one to a self-resetting clear location. After reset the enable is closed, so the line stays quiet until a driver opens it.

The line is wired-OR. The block never drives it high. It only outputs a pull-low enable, and the pad drives zero while that enable is 1 and floats otherwise.

The active edge is chosen by a parameter. Under the default parameters it is the rising edge.

Top module: `edge_level_irq_bridge`

## Requirements
- R1: An active (rising) edge on `req_edge_i` sets the sticky latch. The latch stays set after the request returns low, so the interrupt line is never a copy of the input.
- R2: With the enable open, when `req_edge_i` rises between two clock edges, `irq_pull_low_o` and the status bit become 1 on the third rising clock edge after that change, and not before.
- R3: After reset the latch and the enable are both 0. `irq_pull_low_o` is 0, and every register reads 0.
- R4: While the enable bit is 0, `irq_pull_low_o` stays 0 even when the latch is set. Closing the enable does not clear the latch.
- R5: Reads are combinational from `reg_addr_i`. Offset 0 returns the latch state in bit 0. Offset 4 returns the enable in bit 0. Offset 8 and every other offset return 0. All bits above bit 0 read as 0.
- R6: A write to offset 8 with bit 0 = 1 clears the latch on that clock edge, and `irq_pull_low_o` falls with it. A write to offset 8 with bit 0 = 0 has no effect.
- R7: If an edge is detected on the same clock edge that a clear write takes effect, the latch stays set.
- R8: Writing 1 to the enable at offset 4 while the latch is set makes `irq_pull_low_o` 1 right after that clock edge.
- R9: A request held high after a clear does not set the latch again. Only a new edge does.
- R10: Writes to offset 0 and to unmapped offsets change neither the latch nor the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| req_edge_i | input | 1 | Asynchronous shared edge request from legacy devices |
| reg_we_i | input | 1 | Register write strobe, one write per cycle |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from the address |
| irq_pull_low_o | output | 1 | 1 = pull the shared interrupt line low; 0 = release it |

## Verification
A request change lands in the status bit and on the line three clock edges later: two synchronizer stages, then the latch. Enable, clear and unmask writes act on the very edge that samples the strobe. Reads are due as soon as the address settles. The bench changes inputs and samples outputs only at falling edges. A reference model that steps on rising edges therefore always holds the value due at each sample. The directed latency case counts falling edges one by one and checks that the line is still low after the first and second rising edges.

// File: rtl/intb_pkg.sv
package intb_pkg;
   // byte offsets of the software-visible locations
   localparam int unsigned OFS_STATUS = 0;
   localparam int unsigned OFS_ENABLE = 4;
   localparam int unsigned OFS_CLEAR  = 8;

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_ENABLE = 2'd1,
      SEL_CLEAR  = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/intb_sync.sv
module intb_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("intb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/intb_edge.sv
module intb_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic pulse_o
);
   localparam logic IDLE_LVL = ~RISING;

   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= IDLE_LVL;
      else        prev_q <= lvl_i;
   end

   if (RISING) begin : g_rise
      assign pulse_o = lvl_i & ~prev_q;
   end else begin : g_fall
      assign pulse_o = ~lvl_i & prev_q;
   end

   // an edge yields a one-cycle pulse; a held level never re-fires
   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);
endmodule

// File: rtl/intb_regs.sv
module intb_regs
   import intb_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
   localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);

   reg_sel_e sel;
   logic     latch_q, mask_q;
   logic     en_hit, clr_hit;

   always_comb begin
      if      (addr_i == A_STATUS) sel = SEL_STATUS;
      else if (addr_i == A_ENABLE) sel = SEL_ENABLE;
      else if (addr_i == A_CLEAR)  sel = SEL_CLEAR;
      else                         sel = SEL_NONE;
   end

   assign en_hit  = we_i && (sel == SEL_ENABLE);
   assign clr_hit = we_i && (sel == SEL_CLEAR) && wdata_i[0];

   // a new event wins over a concurrent clear
   always_ff @(posedge clk) begin
      if (!rst_n) latch_q <= 1'b0;
      else        latch_q <= evt_i | (latch_q & ~clr_hit);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      mask_q <= 1'b0;
      else if (en_hit) mask_q <= wdata_i[0];
   end

   always_comb begin
      rdata_o = '0;
      case (sel)
         SEL_STATUS: rdata_o[0] = latch_q;
         SEL_ENABLE: rdata_o[0] = mask_q;
         default:    rdata_o    = '0;
      endcase
   end

   assign irq_o = latch_q & mask_q;

   assert_edge_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> latch_q);
   assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q && !clr_hit) |=> latch_q);
   assert_mask_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_hit && !wdata_i[0]) |=> !irq_o);
   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !evt_i) |=> (!latch_q && !irq_o));
   assert_race_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && evt_i) |=> latch_q);
   assert_unmask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_hit && wdata_i[0] && latch_q && !clr_hit) |=> irq_o);
endmodule

// File: rtl/edge_level_irq_bridge.sv
module edge_level_irq_bridge #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RISING_EDGE = 1'b1,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_edge_i,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_pull_low_o
);
   if (ADDR_W < 4) begin : g_bad_addr
      $error("edge_level_irq_bridge: ADDR_W must reach offset 8");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("edge_level_irq_bridge: DATA_W must be at least 1");
   end

   logic req_sync, evt_pulse;

   intb_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (~RISING_EDGE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (req_edge_i),
      .q_o   (req_sync)
   );

   intb_edge #(
      .RISING (RISING_EDGE)
   ) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (req_sync),
      .pulse_o (evt_pulse)
   );

   intb_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_pulse),
      .we_i    (reg_we_i),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i),
      .rdata_o (reg_rdata_o),
      .irq_o   (irq_pull_low_o)
   );
endmodule

// File: tb/edge_level_irq_bridge_bench.sv
module edge_level_irq_bridge_bench;
   localparam int AW = 4;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          od;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;   // 125 MHz

   edge_level_irq_bridge #(.ADDR_W(AW), .DATA_W(DW)) u_edge_level_irq_bridge (
      .clk(clk), .rst_n(rst_n), .req_edge_i(req), .reg_we_i(we),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .irq_pull_low_o(od));

   // reference model built from the requirements
   logic m_s0 = 0, m_s1 = 0, m_prev = 0, m_latch = 0, m_mask = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_s0 <= 0; m_s1 <= 0; m_prev <= 0; m_latch <= 0; m_mask <= 0;
      end else begin
         m_s0   <= req;
         m_s1   <= m_s0;
         m_prev <= m_s1;
         m_latch <= (m_s1 & ~m_prev) |
                    (m_latch & ~(we && addr == 4'd8 && wdata[0]));
         if (we && addr == 4'd4) m_mask <= wdata[0];
      end
   end

   function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
      logic [DW-1:0] v = '0;
      if (a == 4'd0) v[0] = m_latch;
      else if (a == 4'd4) v[0] = m_mask;
      return v;
   endfunction

   task automatic check(input string req_tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req_tag, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      we = 1; addr = a; wdata = d;
      @(negedge clk);
      we = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input string tag,
                     input logic [DW-1:0] exp);
      addr = a;
      #1;
      check(tag, rdata, exp);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R3: reset state
      check("R3 line", od, 0);
      rd(0, "R3 status", 0);
      rd(4, "R3 enable", 0);
      rd(8, "R3 clear", 0);

      // R4: masked latch, line quiet, status visible
      req = 1; idle(4);
      check("R4 masked line", od, 0);
      rd(0, "R1 latch set", 8'h01);
      req = 0; idle(3);
      rd(0, "R1 sticky after request low", 8'h01);

      // R2: latency with enable open
      wr(4, 8'h01);
      check("R8 unmask latched", od, 1);
      wr(8, 8'h01);
      check("R6 clear drops line", od, 0);
      idle(1);
      req = 1;
      idle(1); check("R2 after edge 1", od, 0);
      idle(1); check("R2 after edge 2", od, 0);
      idle(1); check("R2 after edge 3", od, 1);
      rd(0, "R2 status", 8'h01);

      // R9: held level does not re-trigger
      wr(8, 8'h01);
      idle(5);
      rd(0, "R9 held level", 0);
      check("R9 line", od, 0);

      // R4 closing mask keeps latch; R8 reopen
      req = 0; idle(3);
      req = 1; idle(4);
      wr(4, 8'h00);
      check("R4 closed mask", od, 0);
      rd(0, "R4 latch kept", 8'h01);
      wr(4, 8'hFF);
      check("R8 reopen", od, 1);
      rd(4, "R5 enable readback", 8'h01);

      // R6: clear with bit0 = 0 ignored
      wr(8, 8'hFE);
      rd(0, "R6 zero clear ignored", 8'h01);
      wr(8, 8'h01);
      rd(0, "R6 cleared", 0);
      rd(8, "R5 clear reads 0", 0);

      // R10: ignored writes
      wr(0, 8'hFF);
      rd(0, "R10 status write", 0);
      wr(12, 8'h00);
      rd(4, "R10 unmapped write", 8'h01);
      rd(12, "R5 unmapped read", 0);

      // R7: edge and clear on the same clock edge
      req = 0; idle(3);
      @(negedge clk); req = 1;
      @(negedge clk);
      @(negedge clk); we = 1; addr = 8; wdata = 8'h01;
      @(negedge clk); we = 0;
      rd(0, "R7 race keeps latch", 8'h01);
      check("R7 line", od, 1);
      wr(8, 8'h01);
      rd(0, "R7 later clear", 0);

      // random phase against the model
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         #1;
         check("R4 line vs model", od, m_latch & m_mask);
         check("R5 read vs model", rdata, exp_read(addr));
         if ($urandom_range(0, 5) == 0) req = ~req;
         we = ($urandom_range(0, 3) == 0);
         case ($urandom_range(0, 4))
            0: addr = 0;
            1: addr = 4;
            2: addr = 8;
            3: addr = 12;
            default: addr = AW'($urandom);
         endcase
         wdata = DW'($urandom);
      end
      @(negedge clk); we = 0;

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule